// File: doc/BRIEF.md
# Baud-Framed Serial Symbol Receiver

This block sits at the front-end end of a three-wire transmit link from a line-coding DSP. It runs entirely on the 48x oversampling clock and treats the baud-rate clock as a plain data input. A rising transition on that baud input marks the start of a symbol period. The block then captures a 16-bit serial word, most significant bit first, on the sixteen sampling edges that follow.

Right after the last bit is taken, the block passes the quaternary line symbol, carried in the two top bits of the word, to a downstream pulse former. It does this with a one-cycle strobe, a 2-bit code and a signed level. Exactly 24 cycles after that strobe it pulses a marker for the moment the shaped analog pulse peaks.

The period counter keeps running on a 48-cycle grid when a baud transition is missing. A baud transition that arrives off that grid sets a sticky error and restarts the framing from the new transition.

Top module: `baud_symbol_rx`

## Requirements
- R1: While reset is asserted (rst_ni low, asynchronous), sym_stb_o, peak_o and frame_err_o are 0, and sym_code_o and sym_level_o are 0.
- R2: An edge at which baud_i is sampled 1, where it was sampled 0 at the previous edge, is edge 0 of a period. sdata_i is captured on edges 1 to 16 of that period, bit 15 first and bit 0 on edge 16.
- R3: After reset, no strobe is issued until a baud rising transition has been seen. Serial data that arrives before then has no effect.
- R4: sym_stb_o is high for exactly the one cycle after edge 16 of each period, and is low at all other times.
- R5: While sym_stb_o is high, sym_code_o holds bits 15:14 of the word just captured, with bit 15 on sym_code_o[1].
- R6: While sym_stb_o is high, sym_level_o holds the symbol level as a 3-bit two's-complement value: code 10 gives +3, 11 gives +1, 01 gives -1 and 00 gives -3.
- R7: peak_o is high for exactly one cycle, 24 cycles after the cycle in which sym_stb_o was high. A later strobe restarts this delay.
- R8: A baud rising transition that lands on an edge other than a multiple of 48 edges after the last period start sets frame_err_o. The flag stays set until reset, and the new transition becomes edge 0 of a new period.
- R9: Word bits 13:0, data outside edges 1 to 16, and how long baud_i stays high have no effect on any output.
- R10: If no baud rising transition comes at the 48-edge boundary, the next period starts there anyway. The word is still captured and strobed, and no error is flagged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | 48x oversampling clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| baud_i | input | 1 | Baud-rate framing clock, sampled as data |
| sdata_i | input | 1 | Serial word data, MSB first |
| sym_stb_o | output | 1 | One-cycle symbol transfer strobe |
| sym_code_o | output | 2 | Symbol code, bits 15:14 of the word |
| sym_level_o | output | 3 | Signed symbol level (+3, +1, -1, -3) |
| peak_o | output | 1 | One-cycle pulse-peak marker |
| frame_err_o | output | 1 | Sticky off-grid baud transition flag |

## Verification
The cases that are hard to reach from the ports are the framing corner cases. One is a period that has no baud transition, where the free-running grid must still strobe a word. The other is an off-grid transition, where the error flag must rise while the word capture restarts and an earlier peak marker still fires on time. The bench reaches both by withholding the baud rise for a full period, and by sending periods of 30 and 60 cycles among normal ones. Through all of this it keeps one global edge index and predicts every output arithmetically from the last period start.

// File: rtl/bsr_pkg.sv
package bsr_pkg;

  // Map a 2-bit quaternary code to a signed line level.
  function automatic logic signed [2:0] code_to_level(input logic [1:0] code);
    logic signed [2:0] lvl;
    case (code)
      2'b10:   lvl = 3'sd3;
      2'b11:   lvl = 3'sd1;
      2'b01:   lvl = -3'sd1;
      default: lvl = -3'sd3;
    endcase
    return lvl;
  endfunction

endpackage

// File: rtl/bsr_framer.sv
module bsr_framer #(
  parameter int BAUD_LEN = 48,
  parameter int WORD_W   = 16,
  localparam int PH_W    = $clog2(BAUD_LEN + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            baud_i,
  output logic            shift_en_o,
  output logic            last_bit_o,
  output logic            locked_o,
  output logic [PH_W-1:0] phase_o,
  output logic            frame_err_o
);

  logic            baud_prev_q, baud_prev_d;
  logic [PH_W-1:0] phase_q, phase_d;
  logic            locked_q, locked_d;
  logic            err_q, err_d;
  logic            rise;

  assign rise = baud_i & ~baud_prev_q;

  // Next-state logic
  always_comb begin
    baud_prev_d = baud_i;
    phase_d     = phase_q;
    locked_d    = locked_q;
    err_d       = err_q;
    if (rise) begin
      phase_d  = PH_W'(1);
      locked_d = 1'b1;
      if (locked_q && (phase_q != PH_W'(BAUD_LEN))) err_d = 1'b1;
    end else if (locked_q) begin
      if (phase_q == PH_W'(BAUD_LEN)) phase_d = PH_W'(1);
      else                            phase_d = phase_q + PH_W'(1);
    end
  end

  // Registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      baud_prev_q <= 1'b0;
      phase_q     <= '0;
      locked_q    <= 1'b0;
      err_q       <= 1'b0;
    end else begin
      baud_prev_q <= baud_prev_d;
      phase_q     <= phase_d;
      locked_q    <= locked_d;
      err_q       <= err_d;
    end
  end

  assign shift_en_o  = locked_q && !rise && (phase_q >= PH_W'(1)) && (phase_q <= PH_W'(WORD_W));
  assign last_bit_o  = locked_q && !rise && (phase_q == PH_W'(WORD_W));
  assign locked_o    = locked_q;
  assign phase_o     = phase_q;
  assign frame_err_o = err_q;

  a_r8_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q |=> err_q);

  a_r8_offgrid_sets_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (locked_q && baud_i && !baud_prev_q && (phase_q != PH_W'(BAUD_LEN))) |=> err_q);

  a_r10_grid_resume: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (locked_q && (phase_q == PH_W'(BAUD_LEN))) |=> (phase_q == PH_W'(1)));

endmodule

// File: rtl/bsr_shifter.sv
module bsr_shifter
  import bsr_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int SYM_W  = 2,
  localparam int SR_W  = WORD_W - 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    sdata_i,
  input  logic                    shift_en_i,
  input  logic                    last_bit_i,
  output logic                    stb_o,
  output logic [SYM_W-1:0]        code_o,
  output logic signed [2:0]       level_o
);

  logic [SR_W-1:0]   sr_q, sr_d;
  logic              stb_q, stb_d;
  logic [SYM_W-1:0]  code_q, code_d;
  logic signed [2:0] level_q, level_d;

  // The first WORD_W-1 bits are held; the final bit only completes the word.
  always_comb begin
    sr_d    = sr_q;
    stb_d   = 1'b0;
    code_d  = code_q;
    level_d = level_q;
    if (shift_en_i) sr_d = {sr_q[SR_W-2:0], sdata_i};
    if (last_bit_i) begin
      stb_d   = 1'b1;
      code_d  = sr_q[SR_W-1 -: SYM_W];
      level_d = code_to_level(sr_q[SR_W-1 -: SYM_W]);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q    <= '0;
      stb_q   <= 1'b0;
      code_q  <= '0;
      level_q <= '0;
    end else begin
      sr_q    <= sr_d;
      stb_q   <= stb_d;
      code_q  <= code_d;
      level_q <= level_d;
    end
  end

  assign stb_o   = stb_q;
  assign code_o  = code_q;
  assign level_o = level_q;

  a_r4_one_cycle_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb_q |=> !stb_q);

  a_r5_code_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !last_bit_i |=> $stable(code_q));

endmodule

// File: rtl/bsr_peak_timer.sv
module bsr_peak_timer #(
  parameter int PEAK_DLY = 24,
  localparam int CNT_W   = $clog2(PEAK_DLY + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic stb_i,
  output logic peak_o
);

  logic [CNT_W-1:0] rem_q, rem_d;
  logic             peak_q, peak_d;

  always_comb begin
    rem_d  = rem_q;
    peak_d = 1'b0;
    if (rem_q == CNT_W'(1)) begin
      peak_d = 1'b1;
      rem_d  = '0;
    end else if (rem_q != '0) begin
      rem_d = rem_q - CNT_W'(1);
    end
    if (stb_i) rem_d = CNT_W'(PEAK_DLY - 1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q  <= '0;
      peak_q <= 1'b0;
    end else begin
      rem_q  <= rem_d;
      peak_q <= peak_d;
    end
  end

  assign peak_o = peak_q;

  a_r7_peak_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    peak_q |=> !peak_q);

  a_r7_timer_armed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb_i |=> (rem_q == CNT_W'(PEAK_DLY - 1)));

endmodule

// File: rtl/baud_symbol_rx.sv
module baud_symbol_rx
  import bsr_pkg::*;
#(
  parameter int BAUD_LEN = 48,
  parameter int WORD_W   = 16,
  parameter int SYM_W    = 2,
  parameter int PEAK_DLY = 24,
  localparam int PH_W    = $clog2(BAUD_LEN + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              baud_i,
  input  logic              sdata_i,
  output logic              sym_stb_o,
  output logic [SYM_W-1:0]  sym_code_o,
  output logic [2:0]        sym_level_o,
  output logic              peak_o,
  output logic              frame_err_o
);

  // Reset: asserted asynchronously, released on the clock.
  logic [1:0] rst_sync_q;
  logic       rst_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  logic              shift_en, last_bit, locked;
  logic [PH_W-1:0]   phase;
  logic signed [2:0] level;

  bsr_framer #(.BAUD_LEN(BAUD_LEN), .WORD_W(WORD_W)) u_framer (
    .clk_i      (clk_i),
    .rst_ni     (rst_n),
    .baud_i     (baud_i),
    .shift_en_o (shift_en),
    .last_bit_o (last_bit),
    .locked_o   (locked),
    .phase_o    (phase),
    .frame_err_o(frame_err_o)
  );

  bsr_shifter #(.WORD_W(WORD_W), .SYM_W(SYM_W)) u_shifter (
    .clk_i      (clk_i),
    .rst_ni     (rst_n),
    .sdata_i    (sdata_i),
    .shift_en_i (shift_en),
    .last_bit_i (last_bit),
    .stb_o      (sym_stb_o),
    .code_o     (sym_code_o),
    .level_o    (level)
  );

  bsr_peak_timer #(.PEAK_DLY(PEAK_DLY)) u_peak (
    .clk_i  (clk_i),
    .rst_ni (rst_n),
    .stb_i  (sym_stb_o),
    .peak_o (peak_o)
  );

  assign sym_level_o = level;

  a_r3_no_strobe_unlocked: assert property (@(posedge clk_i) disable iff (!rst_n)
    !locked |-> !sym_stb_o);

  a_r4_strobe_phase: assert property (@(posedge clk_i) disable iff (!rst_n)
    sym_stb_o |-> (phase == PH_W'(WORD_W + 1)));

endmodule

// File: tb/sim_baud_symbol_rx.sv
`timescale 1ns/1ps
module sim_baud_symbol_rx;

  logic       clk = 1'b0;
  logic       rst_ni;
  logic       baud, sdata;
  logic       stb, peak, ferr;
  logic [1:0] code;
  logic [2:0] level;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  // Reference model state (edge indices)
  int  cyc, last_rise, last_strobe;
  bit  locked, exp_err, prev_b, hb, lb;

  always #5 clk = ~clk;

  baud_symbol_rx u0 (
    .clk_i(clk), .rst_ni(rst_ni), .baud_i(baud), .sdata_i(sdata),
    .sym_stb_o(stb), .sym_code_o(code), .sym_level_o(level),
    .peak_o(peak), .frame_err_o(ferr)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s at edge %0d: actual %0d expected %0d", req, cyc, act, exp);
    end
  endtask

  function automatic int lvl_of(input bit h, input bit l);
    return (h ? 1 : -1) * (l ? 1 : 3);
  endfunction

  // Drive one cycle at a falling edge, then check after the next rising edge.
  task automatic tick(input bit b, input bit d);
    int  e, ph;
    bit  ev, ep;
    baud  = b;
    sdata = d;
    e = cyc + 1;
    if (b && !prev_b) begin
      if (locked && ((e - last_rise) % 48) != 0) exp_err = 1;
      last_rise = e;
      locked    = 1;
    end
    prev_b = b;
    ph = locked ? ((e - last_rise) % 48) : -1;
    if (ph == 1) hb = d;
    if (ph == 2) lb = d;
    @(negedge clk);
    cyc = e;
    ev = (ph == 16);
    ep = (e == last_strobe + 24);
    chk("R4 strobe", int'(stb), int'(ev));
    if (ev) begin
      chk("R5 code", int'(code), int'({hb, lb}));
      chk("R6 level", int'($signed(level)), lvl_of(hb, lb));
      last_strobe = e;
    end
    chk("R7 peak", int'(peak), int'(ep));
    chk("R8 frame error", int'(ferr), int'(exp_err));
  endtask

  // One period of given length: baud high for hi cycles, word on cycles 1..16.
  task automatic period(input logic [15:0] w, input int len, input int hi);
    for (int k = 0; k < len; k++) begin
      bit d;
      d = (k >= 1 && k <= 16) ? w[16 - k] : bit'((k * 7 + len) % 3 == 0);
      tick(bit'(k < hi), d);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    baud = 0; sdata = 0; rst_ni = 0;
    repeat (2) @(negedge clk);
    chk("R1 reset strobe", int'(stb), 0);
    chk("R1 reset peak", int'(peak), 0);
    chk("R1 reset error", int'(ferr), 0);
    chk("R1 reset code", int'(code), 0);
    chk("R1 reset level", int'(level), 0);
    rst_ni = 1;
    locked = 0; exp_err = 0; prev_b = 0; last_strobe = -1000; last_rise = 0;
    for (int i = 0; i < 3; i++) tick(0, 0);
  endtask

  initial begin
    cyc = 0; rst_ni = 1; baud = 0; sdata = 0;
    do_reset();

    // R3: data before any baud rise is ignored
    for (int i = 0; i < 60; i++) tick(0, bit'(i % 2));

    // R2 R4 R5 R6 R7 R9: sweep codes, filler bits and baud duty
    for (int c = 0; c < 4; c++)
      for (int f = 0; f < 4; f++) begin
        logic [15:0] w;
        w = {c[1:0], 14'(f * 16'h1357 ^ 16'h2a5c)};
        period(w, 48, 4 + f * 9 + c);
      end

    // R10: missing baud rise for one period, grid continues
    for (int i = 0; i < 48; i++) tick(0, bit'(i == 1));
    period(16'h4000, 48, 24);
    period(16'h8000, 48, 24);

    // R8: early rise sets error, resyncs; error stays
    period(16'hc000, 30, 12);
    period(16'h0000, 48, 24);
    period(16'h8fff, 48, 24);

    // R1 then R8 with a late rise
    do_reset();
    period(16'h7000, 48, 24);
    period(16'hb000, 60, 24);
    period(16'h4321, 48, 20);
    for (int i = 0; i < 30; i++) tick(0, 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule